// File: doc/BRIEF.md
# MDIO Management Command Engine

This block is a memory-mapped master for the two-wire PHY management bus (Clause 22 framing). Software places an entire transaction in one 32-bit command word: a start strobe, a 5-bit PHY address, a 5-bit register number, 16 bits of write data and a 2-bit opcode. The block then runs the whole frame on the management clock and data lines without further help from software.

While a frame is running, a pending flag is set in the status word. When a read frame finishes, the block places the 16 received bits in a read-result word, with two error flags above them. The result is valid only when both flags are zero. The management clock comes from the system clock through a divider that software can set. It stays low between frames, so the pending flag always clears after a fixed number of cycles, even when no PHY answers.

Top module: `mdio_cmd_engine`

## Requirements
- R1: After reset the pending flag (status bit 3) is 0, the read-result word is 0, the divider word reads 9, MDC is low and MDIO is released (`mdio_oe` = 0).
- R2: A write to word address 0 is accepted as a command when bit 31 is 1, no frame is pending, and the opcode in bits 2:1 is 1 (write) or 2 (read). The PHY address comes from bits 29:25, the register number from bits 24:20 and the write data from bits 19:4. The pending flag is 1 from the first cycle after the accepting edge.
- R3: Each frame puts 64 bits on the line, MSB first, in this order: 32 ones, then `01`, then the opcode bits (`01` write, `10` read), then the 5-bit PHY address, the 5-bit register number, two turnaround bits (`10` driven on a write) and 16 data bits.
- R4: MDC has a half period of D+1 system cycles, where D is the divider word (word address 3, bits 7:0). MDC stays low while no frame is pending. The pending flag stays 1 for exactly 128·(D+1) cycles after the accepting edge and then clears.
- R5: The block changes MDIO only on the system edge where MDC falls. It samples `mdio_i` on the system edge where MDC rises.
- R6: On a read, the block releases MDIO from the first turnaround bit to the end of the frame. When the frame completes, the 16 sampled data bits go to bits 15:0 of the read-result word (word address 2), and bit 16 is 0 if the PHY drove the second turnaround bit low.
- R7: If the second turnaround bit of a read is sampled high (no PHY answered), bit 16 of the read-result word is set. The pending flag still clears on time.
- R8: A command with bit 31 set and opcode 0 or 3 starts no frame and never sets the pending flag. On the next cycle the read-result word becomes 0x20000 (bit 17 set, data 0).
- R9: A command write with bit 31 = 0 is ignored. Any command write while a frame is pending is ignored: no extra frame is sent and the read-result word is unchanged.
- R10: A completed write frame leaves the read-result word unchanged.
- R11: Writes to the divider word take effect only while no frame is pending. While a frame is pending they are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register word address for writes (0 command, 3 divider) |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register word address for reads (1 status, 2 read result, 3 divider) |
| rd_data | output | 32 | Combinational read data for `rd_addr` |
| mdc | output | 1 | Management clock, low when idle |
| mdio_o | output | 1 | Management data driven by the block |
| mdio_oe | output | 1 | Drive enable for `mdio_o` |
| mdio_i | input | 1 | Management data seen on the line |

## Verification
The pending flag rises one cycle after the command edge and falls exactly 128·(D+1) cycles after it. The bench counts falling system edges from the command strobe and reads the status word at the last cycle it must still be high and the first cycle it must be low. The read-result word becomes valid on the same edge that clears the pending flag, and the bench reads it only after that edge. An invalid-opcode command updates the read-result word on the edge after the strobe. A PHY model in the bench samples the line on each MDC rise, and a scoreboard compares each full 64-bit frame against the frame the driver queued. The same monitor measures the MDC period against the divider setting.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    typedef enum logic [1:0] {
        RA_CMD   = 2'd0,
        RA_STAT  = 2'd1,
        RA_RDATA = 2'd2,
        RA_DIV   = 2'd3
    } reg_addr_e;

    typedef enum logic [1:0] {
        OPC_NONE = 2'd0,
        OPC_WR   = 2'd1,
        OPC_RD   = 2'd2,
        OPC_BAD  = 2'd3
    } opcode_e;

    localparam int START_BIT = 31;
    localparam int PEND_BIT  = 3;
    localparam int TAERR_BIT = 16;
    localparam int OPERR_BIT = 17;
    localparam int BODY_BITS = 32;

    typedef struct packed {
        logic [4:0]  phy;
        logic [4:0]  regad;
        logic [15:0] wdata;
        opcode_e     op;
    } cmd_t;

    typedef struct packed {
        logic        ta_err;
        logic [15:0] data;
    } rd_result_t;

    function automatic cmd_t unpack_cmd(input logic [31:0] w);
        cmd_t c;
        c.phy   = w[29:25];
        c.regad = w[24:20];
        c.wdata = w[19:4];
        c.op    = opcode_e'(w[2:1]);
        return c;
    endfunction

    function automatic logic op_valid(input opcode_e op);
        return (op == OPC_WR) || (op == OPC_RD);
    endfunction

    // Bits after the preamble: start, opcode, addresses, turnaround, data.
    function automatic logic [BODY_BITS-1:0] frame_body(input cmd_t c);
        logic [1:0]  ta;
        logic [15:0] d;
        ta = (c.op == OPC_RD) ? 2'b11 : 2'b10;
        d  = (c.op == OPC_RD) ? 16'hFFFF : c.wdata;
        return {2'b01, c.op, c.phy, c.regad, ta, d};
    endfunction

endpackage

// File: rtl/mdio_mdc_timer.sv
module mdio_mdc_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == div);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // The half-period counter never passes the divider value during a frame.
    assert_count_bound_R4: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt <= div));

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_pkg::*;
#(
    parameter int PRE_LEN = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  cmd_t       cmd,
    input  logic       tick,
    input  logic       mdio_i,
    output logic       busy,
    output logic       mdc,
    output logic       mdio_o,
    output logic       mdio_oe,
    output logic       rd_done,
    output rd_result_t result
);
    localparam int FRAME = PRE_LEN + BODY_BITS;
    localparam int IW    = $clog2(FRAME);
    localparam logic [IW-1:0] IDX_REL  = IW'(PRE_LEN + 14);
    localparam logic [IW-1:0] IDX_TA2  = IW'(PRE_LEN + 15);
    localparam logic [IW-1:0] IDX_DAT  = IW'(PRE_LEN + 16);
    localparam logic [IW-1:0] IDX_LAST = IW'(FRAME - 1);

    logic [FRAME-1:0] sh;
    logic [IW-1:0]    bit_idx;
    logic             is_read;
    logic             ta_err;
    logic [15:0]      rx;
    logic             rise_now;
    logic             fall_now;

    assign rise_now = tick && !mdc;
    assign fall_now = tick && mdc;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            mdc     <= 1'b0;
            sh      <= '1;
            bit_idx <= '0;
            is_read <= 1'b0;
            ta_err  <= 1'b0;
            rx      <= '0;
        end else if (start && !busy) begin
            busy    <= 1'b1;
            mdc     <= 1'b0;
            sh      <= {{PRE_LEN{1'b1}}, frame_body(cmd)};
            bit_idx <= '0;
            is_read <= (cmd.op == OPC_RD);
            ta_err  <= 1'b0;
            rx      <= '0;
        end else if (rise_now) begin
            mdc <= 1'b1;
            if (is_read && bit_idx == IDX_TA2) begin
                ta_err <= mdio_i;
            end
            if (is_read && bit_idx >= IDX_DAT) begin
                rx <= {rx[14:0], mdio_i};
            end
        end else if (fall_now) begin
            mdc <= 1'b0;
            if (bit_idx == IDX_LAST) begin
                busy <= 1'b0;
                sh   <= '1;
            end else begin
                bit_idx <= bit_idx + 1'b1;
                sh      <= {sh[FRAME-2:0], 1'b1};
            end
        end
    end

    assign mdio_o  = busy ? sh[FRAME-1] : 1'b1;
    assign mdio_oe = busy && !(is_read && bit_idx >= IDX_REL);
    assign rd_done = fall_now && is_read && (bit_idx == IDX_LAST);
    assign result  = '{ta_err: ta_err, data: rx};

    assert_mdc_idle_low_R4: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdc);

    assert_drive_on_fall_R5: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !$stable(mdio_o)) |-> $fell(mdc));

    assert_release_on_fall_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(mdio_oe) |-> $fell(mdc));

endmodule

// File: rtl/mdio_regfile.sv
module mdio_regfile
    import mdio_pkg::*;
#(
    parameter int          DIV_W   = 8,
    parameter logic [7:0]  DIV_RST = 8'd9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [31:0]      wr_data,
    input  logic [1:0]       rd_addr,
    output logic [31:0]      rd_data,
    input  logic             busy,
    input  logic             rd_done,
    input  rd_result_t       result,
    output logic             start,
    output cmd_t             cmd,
    output logic [DIV_W-1:0] div
);
    logic [OPERR_BIT:0] data_q;
    logic [DIV_W-1:0]   div_q;
    logic               cmd_wr;
    logic               bad_cmd;
    logic               unused_bits;

    assign cmd         = unpack_cmd(wr_data);
    assign cmd_wr      = wr_en && (wr_addr == RA_CMD) && wr_data[START_BIT] && !busy;
    assign start       = cmd_wr && op_valid(cmd.op);
    assign bad_cmd     = cmd_wr && !op_valid(cmd.op);
    assign div         = div_q;
    assign unused_bits = ^{wr_data[30], wr_data[3], wr_data[0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            div_q  <= DIV_W'(DIV_RST);
        end else begin
            if (rd_done) begin
                data_q <= {1'b0, result};
            end else if (bad_cmd) begin
                data_q <= {1'b1, 1'b0, 16'h0000};
            end
            if (wr_en && (wr_addr == RA_DIV) && !busy) begin
                div_q <= wr_data[DIV_W-1:0];
            end
        end
    end

    always_comb begin
        rd_data = '0;
        case (reg_addr_e'(rd_addr))
            RA_STAT:  rd_data[PEND_BIT] = busy;
            RA_RDATA: rd_data[OPERR_BIT:0] = data_q;
            RA_DIV:   rd_data[DIV_W-1:0] = div_q;
            default:  rd_data = '0;
        endcase
    end

    assert_cmd_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && !rd_done && wr_en && wr_addr == RA_CMD) |=> $stable(data_q));

    assert_div_locked_R11: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_en && wr_addr == RA_DIV) |=> $stable(div_q));

endmodule

// File: rtl/mdio_cmd_engine.sv
module mdio_cmd_engine
    import mdio_pkg::*;
#(
    parameter int         PRE_LEN = 32,
    parameter int         DIV_W   = 8,
    parameter logic [7:0] DIV_RST = 8'd9
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic [1:0]  rd_addr,
    output logic [31:0] rd_data,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic             busy;
    logic             start;
    logic             tick;
    logic             rd_done;
    cmd_t             cmd;
    rd_result_t       result;
    logic [DIV_W-1:0] div;

    mdio_regfile #(.DIV_W(DIV_W), .DIV_RST(DIV_RST)) u_regs (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .busy(busy), .rd_done(rd_done), .result(result),
        .start(start), .cmd(cmd), .div(div)
    );

    mdio_mdc_timer #(.DIV_W(DIV_W)) u_timer (
        .clk(clk), .rst(rst), .run(busy), .div(div), .tick(tick)
    );

    mdio_frame_engine #(.PRE_LEN(PRE_LEN)) u_frame (
        .clk(clk), .rst(rst), .start(start), .cmd(cmd), .tick(tick),
        .mdio_i(mdio_i), .busy(busy), .mdc(mdc), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe), .rd_done(rd_done), .result(result)
    );

endmodule

// File: tb/mdio_cmd_engine_test.sv
module mdio_cmd_engine_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = 2'd1;
    logic [31:0] rd_data;
    logic        mdc, mdio_o, mdio_oe, mdio_i;

    int vectors = 0;
    int miscompares = 0;
    int cyc = 0;
    bit done_flag = 0;

    // PHY model state
    bit          phy_rd = 0, phy_resp = 0, phy_drv = 0, phy_val = 1;
    logic [15:0] phy_data = '0;
    int          rcount = 0;
    int          t_first = 0;
    int          cur_div = 9;
    logic [63:0] obs;
    logic [63:0] exp_q[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc++;

    assign mdio_i = mdio_oe ? mdio_o : (phy_drv ? phy_val : 1'b1);

    mdio_cmd_engine uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .mdc(mdc), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: sample the line on each MDC rise and compare whole frames.
    always @(posedge mdc) begin
        obs[63-rcount] = mdio_i;
        if (rcount == 0) t_first = cyc;
        if (rcount == 1) chk("R4 mdc period", cyc - t_first, 2 * (cur_div + 1));
        rcount++;
        if (rcount == 64) begin
            if (exp_q.size() == 0) begin
                chk("R9 unexpected frame", 1, 0);
            end else begin
                chk("R3 R5 frame bits hi", obs[63:32], exp_q[0][63:32]);
                chk("R3 R5 frame bits lo", obs[31:0], exp_q[0][31:0]);
                void'(exp_q.pop_front());
            end
            rcount = 0;
        end
    end

    // PHY answer: drive after MDC falls so the value is stable at the next rise.
    always @(negedge mdc) begin
        if (phy_rd && phy_resp && rcount == 47) begin
            phy_drv = 1; phy_val = 0;
        end else if (phy_rd && phy_resp && rcount >= 48 && rcount <= 63) begin
            phy_drv = 1; phy_val = phy_data[63-rcount];
        end else begin
            phy_drv = 0;
        end
    end

    function automatic logic [63:0] exp_frame(input logic [1:0] op, input logic [4:0] phy,
                                              input logic [4:0] ra, input logic [15:0] wd,
                                              input bit resp, input logic [15:0] rdv);
        logic [1:0]  ta;
        logic [15:0] d;
        if (op == 2'd1) begin ta = 2'b10; d = wd; end
        else if (resp)  begin ta = 2'b10; d = rdv; end
        else            begin ta = 2'b11; d = 16'hFFFF; end
        return {32'hFFFF_FFFF, 2'b01, op, phy, ra, ta, d};
    endfunction

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
        rd_addr = a; #1; d = rd_data;
    endtask

    // Driver: queue the expected frame, issue the command, check pending timing.
    task automatic run_cmd(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] ra,
                           input logic [15:0] wd, input bit resp, input logic [15:0] rdv,
                           input bit interfere);
        int t;
        exp_q.push_back(exp_frame(op, phy, ra, wd, resp, rdv));
        phy_rd = (op == 2'd2); phy_resp = resp; phy_data = rdv;
        rd_addr = 2'd1;
        @(negedge clk); wr_en = 1; wr_addr = 2'd0;
        wr_data = {1'b1, 1'b0, phy, ra, wd, 1'b0, op, 1'b0};
        @(negedge clk); wr_en = 0;
        chk("R2 pending after accept", rd_data[3], 1);
        t = 128 * (cur_div + 1);
        for (int k = 1; k <= t; k++) begin
            @(negedge clk);
            if (interfere && k == 10) begin
                wr_en = 1; wr_addr = 2'd0; wr_data = 32'h8000_0014;
            end
            if (interfere && k == 11) begin
                wr_addr = 2'd3; wr_data = 32'h0000_0000;
            end
            if (interfere && k == 12) wr_en = 0;
            if (k == t - 1) chk("R4 pending held", rd_data[3], 1);
            if (k == t)     chk("R4 pending cleared", rd_data[3], 0);
        end
        chk("R3 frame consumed", exp_q.size(), 0);
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        rd_reg(2'd1, v); chk("R1 pending reset", v, 0);
        rd_reg(2'd2, v); chk("R1 result reset", v, 0);
        rd_reg(2'd3, v); chk("R1 divider reset", v, 9);
        chk("R1 mdc low", mdc, 0);
        chk("R1 mdio released", mdio_oe, 0);

        wr_reg(2'd3, 32'd1); cur_div = 1;
        rd_reg(2'd3, v); chk("R11 divider write idle", v, 1);

        // write frame, then result word unchanged
        run_cmd(2'd1, 5'h05, 5'h03, 16'hA5C3, 0, 16'h0, 0);
        rd_reg(2'd2, v); chk("R10 result after write", v, 0);

        // read with PHY answering
        run_cmd(2'd2, 5'h1F, 5'h00, 16'h0, 1, 16'h1234, 0);
        rd_reg(2'd2, v); chk("R6 read data", v, 32'h0000_1234);

        // read with no PHY
        run_cmd(2'd2, 5'h0A, 5'h11, 16'h0, 0, 16'h0, 0);
        rd_reg(2'd2, v); chk("R7 no-answer flag", v, 32'h0001_FFFF);

        // slower clock, with writes during the frame
        wr_reg(2'd3, 32'd3); cur_div = 3;
        run_cmd(2'd2, 5'h00, 5'h1F, 16'h0, 1, 16'h8001, 1);
        rd_reg(2'd2, v); chk("R6 read data slow", v, 32'h0000_8001);
        rd_reg(2'd3, v); chk("R11 divider held", v, 3);
        repeat (40) @(negedge clk);
        chk("R9 no extra frame", rcount, 0);
        chk("R9 queue empty", exp_q.size(), 0);

        // start bit clear: ignored
        rd_addr = 2'd1;
        @(negedge clk); wr_en = 1; wr_addr = 2'd0; wr_data = 32'h0A30_0004;
        @(negedge clk); wr_en = 0;
        chk("R9 no start bit", rd_data[3], 0);
        repeat (20) @(negedge clk);
        chk("R9 no start no frame", rcount, 0);
        rd_reg(2'd2, v); chk("R9 result kept", v, 32'h0000_8001);

        // invalid opcodes
        rd_addr = 2'd1;
        @(negedge clk); wr_en = 1; wr_addr = 2'd0; wr_data = 32'h8A30_0006;
        @(negedge clk); wr_en = 0;
        chk("R8 opcode 3 no pending", rd_data[3], 0);
        rd_reg(2'd2, v); chk("R8 opcode 3 flag", v, 32'h0002_0000);
        wr_reg(2'd2, 32'h0); // no effect on any state
        @(negedge clk); wr_en = 1; wr_addr = 2'd0; wr_data = 32'h8000_0000;
        @(negedge clk); wr_en = 0;
        rd_reg(2'd2, v); chk("R8 opcode 0 flag", v, 32'h0002_0000);
        repeat (20) @(negedge clk);
        chk("R8 no frame", rcount, 0);
        chk("R4 mdc idle", mdc, 0);

        // a good read clears the flags
        run_cmd(2'd2, 5'h15, 5'h0A, 16'h0, 1, 16'h0000, 0);
        rd_reg(2'd2, v); chk("R6 flags cleared", v, 0);

        if (!done_flag) begin
            done_flag = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1;
            vectors++; miscompares++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule